// File: doc/BRIEF.md
# Chained MAC Table Search Engine

This block resolves one forwarding request for a packet switch. It receives the source MAC address, the destination MAC address and the VLAN ID taken from a frame header. It sorts the destination into unicast, multicast or broadcast. It then looks up the source and the destination in a MAC table. The result is a response record that tells the frame scheduler whether to learn the source, whether to flood the frame, and where to send it.

The table is split between two memories. Each key is hashed to a bucket. The first entry of every bucket chain is read from an external memory through a request/valid handshake with variable latency. The chain then continues in an on-chip entry store, reached through next pointers. An entry matches only when both its MAC and its VLAN ID are equal to the key. The walk stops at the end of the chain or at a hop cap, whichever comes first.

When a unicast destination entry is flagged as a trunk, the response carries the trunk number. It also carries a member index, computed from both MAC addresses, which spreads the flows across the links of the trunk.

Top module: `mt_search_engine`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_done` and `ext_rd_req` are 0.
- R2: The bucket of a key is the low `BKT_W` bits of the XOR of the four 12-bit slices of the MAC (bits 47:36, 35:24, 23:12 and 11:0) and the VLAN ID. It appears on `ext_rd_addr` while `ext_rd_req` is high. The source is looked up first, then the destination.
- R3: One request is handled at a time. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the cycle in which `resp_done` is high. Request inputs presented while busy have no effect.
- R4: `ext_rd_req` is a one-cycle pulse for each chain head. The engine waits any number of cycles for `ext_rd_valid` and takes `ext_rd_data` in that cycle.
- R5: An entry is 82 bits: {valid[81], mac[80:33], vid[32:21], trunk[20], fwd[19:12], next[11:0]}. An entry matches only if valid is 1 and both MAC and VID are equal to the key. On a mismatch, the walk follows `next` into the internal store, which is written through `tbl_wr_*`. `next` = 12'hFFF ends the chain.
- R6: At most `MAX_HOPS` internal entries are examined per lookup. A key that lies further down the chain is reported as a miss.
- R7: `resp_learn` is 1 when the source lookup misses and 0 when it hits.
- R8: A destination of all ones gives `resp_kind` = 2 (broadcast) and `resp_flood` = 1. In that case no destination lookup is made, so there is only one external read.
- R9: A destination with bit 40 set that is not all ones gives `resp_kind` = 1. A hit returns the entry's fwd as a port mask, with `resp_trunk` = 0 even if the entry's trunk flag is set. Otherwise `resp_kind` = 0.
- R10: A destination miss gives `resp_flood` = 1. On any flood, `resp_fwd`, `resp_trunk` and `resp_member` are 0.
- R11: On a unicast hit on a non-trunk entry, `resp_fwd` is the entry's fwd. On a unicast hit on a trunk entry, `resp_trunk` = 1 and `resp_fwd` = fwd[2:0], the trunk number. `resp_member` = (src[2:0] XOR dst[2:0]) mod N, where N is `trunk_cnt[4*t+3:4*t]` for trunk t. If N = 0, the member is 0.
- R12: `resp_done` is high for exactly one cycle per accepted request, and all `resp_*` fields are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_src_mac | input | 48 | Source MAC |
| req_dst_mac | input | 48 | Destination MAC |
| req_vid | input | 12 | VLAN ID |
| ext_rd_req | output | 1 | Chain-head read pulse |
| ext_rd_addr | output | BKT_W | Bucket index |
| ext_rd_valid | input | 1 | Head entry returned |
| ext_rd_data | input | 82 | Head entry |
| tbl_wr_en | input | 1 | Internal entry write |
| tbl_wr_addr | input | $clog2(INT_DEPTH) | Internal entry index |
| tbl_wr_data | input | 82 | Internal entry |
| trunk_cnt | input | 4*NTRUNK | Member count per trunk |
| resp_done | output | 1 | Response strobe |
| resp_kind | output | 2 | 0 unicast, 1 multicast, 2 broadcast |
| resp_learn | output | 1 | Source unknown |
| resp_flood | output | 1 | Destination unknown or broadcast |
| resp_trunk | output | 1 | Destination is a trunk |
| resp_fwd | output | 8 | Port, port mask or trunk number |
| resp_member | output | 3 | Trunk member index |

## Verification
The bench builds the engine with `BKT_W` = 4, `INT_DEPTH` = 16 and `MAX_HOPS` = 3. With 16 buckets, the keys collide often, and the bench can compute where each key lands. With a cap of three hops, one chain can put a key exactly at the cap and another just past it. The external memory model answers with a latency that rotates between one and four cycles, so the wait state is exercised with both short and long gaps.

// File: rtl/mt_pkg.sv
// Package: shared entry layout, kind codes and the bucket fold function.
// Assumes a 48-bit MAC, 12-bit VLAN ID and 12-bit next pointer.
package mt_pkg;
    localparam int MAC_W   = 48;
    localparam int VID_W   = 12;
    localparam int FWD_W   = 8;
    localparam int PTR_W   = 12;
    localparam int TRUNK_W = 3;
    localparam int TCNT_W  = 4;
    localparam logic [PTR_W-1:0] PTR_END = '1;

    typedef struct packed {
        logic             valid;
        logic [MAC_W-1:0] mac;
        logic [VID_W-1:0] vid;
        logic             trunk;
        logic [FWD_W-1:0] fwd;
        logic [PTR_W-1:0] next;
    } mt_entry_t;

    localparam int ENTRY_W = $bits(mt_entry_t);

    typedef enum logic [1:0] {
        KIND_UC = 2'd0,
        KIND_MC = 2'd1,
        KIND_BC = 2'd2
    } mt_kind_t;

    // XOR fold of the four 12-bit MAC slices with the VLAN ID
    function automatic logic [11:0] mt_fold(input logic [MAC_W-1:0] mac,
                                            input logic [VID_W-1:0] vid);
        return mac[47:36] ^ mac[35:24] ^ mac[23:12] ^ mac[11:0] ^ vid;
    endfunction
endpackage

// File: rtl/mt_chain_ram.sv
// Internal chain entry store: one write port, one registered read port.
// Assumes writes and chain walks do not target the same entry at once.
module mt_chain_ram
    import mt_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);
    logic [ENTRY_W-1:0] mem [DEPTH];

    // write port and registered read
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/mt_chain_walker.sv
// Walks one bucket chain: it fetches the head from external memory, then
// follows the next pointers through the internal store, comparing MAC and VID.
// Assumes the key is stable on the cycle start is high. The result is
// registered and qualified by a one-cycle done pulse.
module mt_chain_walker
    import mt_pkg::*;
#(
    parameter int BKT_W    = 10,
    parameter int IDX_W    = 11,
    parameter int MAX_HOPS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MAC_W-1:0]   key_mac,
    input  logic [VID_W-1:0]   key_vid,
    output logic               ext_rd_req,
    output logic [BKT_W-1:0]   ext_rd_addr,
    input  logic               ext_rd_valid,
    input  logic [ENTRY_W-1:0] ext_rd_data,
    output logic [IDX_W-1:0]   ram_rd_addr,
    input  logic [ENTRY_W-1:0] ram_rd_data,
    output logic               done,
    output logic               hit,
    output logic               hit_trunk,
    output logic [FWD_W-1:0]   hit_fwd
);
    localparam int HOP_W = $clog2(MAX_HOPS + 1);
    localparam logic [HOP_W-1:0] HOP_LIMIT = HOP_W'(MAX_HOPS);

    typedef enum logic [2:0] {W_IDLE, W_HEAD, W_WAIT, W_IRD, W_ICMP} wstate_t;

    wstate_t          st;
    logic [MAC_W-1:0] key_q;
    logic [VID_W-1:0] vid_q;
    logic [BKT_W-1:0] bkt_q;
    logic [PTR_W-1:0] ptr_q;
    logic [HOP_W-1:0] hops_q;
    logic [11:0]      fold;
    mt_entry_t        cand;
    logic             eval_now;
    logic             is_match;
    logic             at_end;

    // select the entry under test and judge it
    always_comb begin
        fold     = mt_fold(key_mac, key_vid);
        cand     = (st == W_WAIT) ? mt_entry_t'(ext_rd_data) : mt_entry_t'(ram_rd_data);
        eval_now = ((st == W_WAIT) && ext_rd_valid) || (st == W_ICMP);
        is_match = cand.valid && (cand.mac == key_q) && (cand.vid == vid_q);
        at_end   = (cand.next == PTR_END) || (hops_q == HOP_LIMIT);
    end

    assign ext_rd_req  = (st == W_HEAD);
    assign ext_rd_addr = bkt_q;
    assign ram_rd_addr = ptr_q[IDX_W-1:0];

    // walk state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= W_IDLE;
            key_q     <= '0;
            vid_q     <= '0;
            bkt_q     <= '0;
            ptr_q     <= '0;
            hops_q    <= '0;
            done      <= 1'b0;
            hit       <= 1'b0;
            hit_trunk <= 1'b0;
            hit_fwd   <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                W_IDLE: begin
                    if (start) begin
                        key_q  <= key_mac;
                        vid_q  <= key_vid;
                        bkt_q  <= fold[BKT_W-1:0];
                        hops_q <= '0;
                        st     <= W_HEAD;
                    end
                end
                W_HEAD: st <= W_WAIT;
                W_IRD:  st <= W_ICMP;
                default: begin
                    if (eval_now) begin
                        if (is_match) begin
                            done      <= 1'b1;
                            hit       <= 1'b1;
                            hit_trunk <= cand.trunk;
                            hit_fwd   <= cand.fwd;
                            st        <= W_IDLE;
                        end else if (at_end) begin
                            done      <= 1'b1;
                            hit       <= 1'b0;
                            hit_trunk <= 1'b0;
                            hit_fwd   <= '0;
                            st        <= W_IDLE;
                        end else begin
                            ptr_q  <= cand.next;
                            hops_q <= hops_q + 1'b1;
                            st     <= W_IRD;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mt_trunk_pick.sv
// Trunk member selection: XOR of the low MAC bits, reduced modulo the member
// count. Assumes a count of zero means an unconfigured trunk, which gives 0.
module mt_trunk_pick
    import mt_pkg::*;
(
    input  logic [TRUNK_W-1:0] src_lo,
    input  logic [TRUNK_W-1:0] dst_lo,
    input  logic [TCNT_W-1:0]  count,
    output logic [TRUNK_W-1:0] member
);
    logic [TCNT_W-1:0] mix;
    logic [TCNT_W-1:0] rem;

    // hash and reduce
    always_comb begin
        mix    = {1'b0, src_lo ^ dst_lo};
        rem    = (count == '0) ? '0 : (mix % count);
        member = rem[TRUNK_W-1:0];
    end
endmodule

// File: rtl/mt_search_engine.sv
// Search engine top: accepts a request, classifies the destination, looks up
// the source and then the destination, and emits a registered response.
// Assumes the internal store is written only while the engine is idle.
module mt_search_engine
    import mt_pkg::*;
#(
    parameter int BKT_W     = 10,
    parameter int INT_DEPTH = 2048,
    parameter int MAX_HOPS  = 8,
    parameter int NTRUNK    = 8,
    localparam int IDX_W    = $clog2(INT_DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [47:0]              req_src_mac,
    input  logic [47:0]              req_dst_mac,
    input  logic [11:0]              req_vid,
    output logic                     ext_rd_req,
    output logic [BKT_W-1:0]         ext_rd_addr,
    input  logic                     ext_rd_valid,
    input  logic [81:0]              ext_rd_data,
    input  logic                     tbl_wr_en,
    input  logic [IDX_W-1:0]         tbl_wr_addr,
    input  logic [81:0]              tbl_wr_data,
    input  logic [NTRUNK*4-1:0]      trunk_cnt,
    output logic                     resp_done,
    output logic [1:0]               resp_kind,
    output logic                     resp_learn,
    output logic                     resp_flood,
    output logic                     resp_trunk,
    output logic [7:0]               resp_fwd,
    output logic [2:0]               resp_member
);
    typedef enum logic [1:0] {T_IDLE, T_SRC, T_DST} tstate_t;

    tstate_t            state;
    logic [MAC_W-1:0]   src_q;
    logic [MAC_W-1:0]   dst_q;
    logic [VID_W-1:0]   vid_q;
    mt_kind_t           kind_q;
    logic               learn_q;
    logic               w_start;
    logic               w_done;
    logic               w_hit;
    logic               w_trunk;
    logic [FWD_W-1:0]   w_fwd;
    logic [IDX_W-1:0]   ram_rd_addr;
    logic [ENTRY_W-1:0] ram_rd_data;
    logic [TCNT_W-1:0]  cnt_arr [NTRUNK];
    logic [TCNT_W-1:0]  sel_cnt;
    logic [TRUNK_W-1:0] member;
    logic [MAC_W-1:0]   key_mac;

    for (genvar g = 0; g < NTRUNK; g++) begin : g_cnt
        assign cnt_arr[g] = trunk_cnt[g*TCNT_W +: TCNT_W];
    end

    // pick the member count of the trunk named by the hit entry
    always_comb begin
        sel_cnt = '0;
        for (int i = 0; i < NTRUNK; i++) begin
            if (w_fwd[TRUNK_W-1:0] == TRUNK_W'(i)) begin
                sel_cnt = cnt_arr[i];
            end
        end
    end

    assign req_ready = (state == T_IDLE);
    assign key_mac   = (state == T_DST) ? dst_q : src_q;

    mt_chain_ram #(.DEPTH(INT_DEPTH), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_addr (ram_rd_addr),
        .rd_data (ram_rd_data)
    );

    mt_chain_walker #(.BKT_W(BKT_W), .IDX_W(IDX_W), .MAX_HOPS(MAX_HOPS)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (w_start),
        .key_mac      (key_mac),
        .key_vid      (vid_q),
        .ext_rd_req   (ext_rd_req),
        .ext_rd_addr  (ext_rd_addr),
        .ext_rd_valid (ext_rd_valid),
        .ext_rd_data  (ext_rd_data),
        .ram_rd_addr  (ram_rd_addr),
        .ram_rd_data  (ram_rd_data),
        .done         (w_done),
        .hit          (w_hit),
        .hit_trunk    (w_trunk),
        .hit_fwd      (w_fwd)
    );

    mt_trunk_pick u_pick (
        .src_lo (src_q[TRUNK_W-1:0]),
        .dst_lo (dst_q[TRUNK_W-1:0]),
        .count  (sel_cnt),
        .member (member)
    );

    // request sequencing and response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= T_IDLE;
            src_q       <= '0;
            dst_q       <= '0;
            vid_q       <= '0;
            kind_q      <= KIND_UC;
            learn_q     <= 1'b0;
            w_start     <= 1'b0;
            resp_done   <= 1'b0;
            resp_kind   <= 2'd0;
            resp_learn  <= 1'b0;
            resp_flood  <= 1'b0;
            resp_trunk  <= 1'b0;
            resp_fwd    <= '0;
            resp_member <= '0;
        end else begin
            w_start   <= 1'b0;
            resp_done <= 1'b0;
            case (state)
                T_IDLE: begin
                    if (req_valid) begin
                        src_q   <= req_src_mac;
                        dst_q   <= req_dst_mac;
                        vid_q   <= req_vid;
                        if (&req_dst_mac)        kind_q <= KIND_BC;
                        else if (req_dst_mac[40]) kind_q <= KIND_MC;
                        else                      kind_q <= KIND_UC;
                        w_start <= 1'b1;
                        state   <= T_SRC;
                    end
                end
                T_SRC: begin
                    if (w_done) begin
                        learn_q <= !w_hit;
                        if (kind_q == KIND_BC) begin
                            resp_done   <= 1'b1;
                            resp_kind   <= kind_q;
                            resp_learn  <= !w_hit;
                            resp_flood  <= 1'b1;
                            resp_trunk  <= 1'b0;
                            resp_fwd    <= '0;
                            resp_member <= '0;
                            state       <= T_IDLE;
                        end else begin
                            w_start <= 1'b1;
                            state   <= T_DST;
                        end
                    end
                end
                default: begin
                    if (w_done) begin
                        resp_done   <= 1'b1;
                        resp_kind   <= kind_q;
                        resp_learn  <= learn_q;
                        resp_flood  <= !w_hit;
                        resp_trunk  <= w_hit && w_trunk && (kind_q == KIND_UC);
                        resp_member <= '0;
                        resp_fwd    <= '0;
                        if (w_hit) begin
                            if (w_trunk && (kind_q == KIND_UC)) begin
                                resp_fwd    <= {{(FWD_W-TRUNK_W){1'b0}}, w_fwd[TRUNK_W-1:0]};
                                resp_member <= member;
                            end else begin
                                resp_fwd <= w_fwd;
                            end
                        end
                        state <= T_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mt_search_engine_chk.sv
// Protocol checker for the search engine, attached by bind.
module mt_search_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       ext_rd_req,
    input logic       resp_done,
    input logic [1:0] resp_kind,
    input logic       resp_flood,
    input logic       resp_trunk,
    input logic [7:0] resp_fwd,
    input logic [2:0] resp_member
);
    a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r3_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ext_rd_req);
    a_r4_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rd_req |=> !ext_rd_req);
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);
    a_r8_bcast_floods: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_kind == 2'd2) |-> (resp_flood && !resp_trunk));
    a_r10_flood_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_flood) |-> (resp_fwd == 8'd0 && resp_member == 3'd0 && !resp_trunk));
    a_r11_trunk_unicast: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_trunk) |-> (resp_kind == 2'd0));
    a_r11_member_only_trunk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && !resp_trunk) |-> (resp_member == 3'd0));
endmodule

bind mt_search_engine mt_search_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .ext_rd_req  (ext_rd_req),
    .resp_done   (resp_done),
    .resp_kind   (resp_kind),
    .resp_flood  (resp_flood),
    .resp_trunk  (resp_trunk),
    .resp_fwd    (resp_fwd),
    .resp_member (resp_member)
);

// File: tb/mt_search_engine_bench.sv
module mt_search_engine_bench;
    localparam int BKT_W     = 4;
    localparam int INT_DEPTH = 16;
    localparam int MAX_HOPS  = 3;
    localparam int NTRUNK    = 8;
    localparam int IDX_W     = 4;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [47:0]       req_src_mac = '0;
    logic [47:0]       req_dst_mac = '0;
    logic [11:0]       req_vid = '0;
    logic              ext_rd_req;
    logic [BKT_W-1:0]  ext_rd_addr;
    logic              ext_rd_valid = 1'b0;
    logic [81:0]       ext_rd_data = '0;
    logic              tbl_wr_en = 1'b0;
    logic [IDX_W-1:0]  tbl_wr_addr = '0;
    logic [81:0]       tbl_wr_data = '0;
    logic [NTRUNK*4-1:0] trunk_cnt = '0;
    logic              resp_done;
    logic [1:0]        resp_kind;
    logic              resp_learn;
    logic              resp_flood;
    logic              resp_trunk;
    logic [7:0]        resp_fwd;
    logic [2:0]        resp_member;

    int n_tests = 0;
    int n_fail  = 0;
    int n_ext   = 0;
    int alloc   = 0;
    bit in_req  = 0;

    logic [81:0]      head_m  [16];
    logic [81:0]      chain_m [16];
    logic [BKT_W-1:0] exp_addr [$];

    always #2.5 clk = ~clk;

    mt_search_engine #(.BKT_W(BKT_W), .INT_DEPTH(INT_DEPTH), .MAX_HOPS(MAX_HOPS),
                       .NTRUNK(NTRUNK)) u_mt_search_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src_mac(req_src_mac), .req_dst_mac(req_dst_mac), .req_vid(req_vid),
        .ext_rd_req(ext_rd_req), .ext_rd_addr(ext_rd_addr), .ext_rd_valid(ext_rd_valid),
        .ext_rd_data(ext_rd_data), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data), .trunk_cnt(trunk_cnt), .resp_done(resp_done),
        .resp_kind(resp_kind), .resp_learn(resp_learn), .resp_flood(resp_flood),
        .resp_trunk(resp_trunk), .resp_fwd(resp_fwd), .resp_member(resp_member));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [81:0] mk(input bit v, input logic [47:0] mac, input logic [11:0] vid,
                                       input bit tr, input logic [7:0] fwd, input logic [11:0] nxt);
        return {v, mac, vid, tr, fwd, nxt};
    endfunction

    // R2 bucket: fold of four MAC slices and the VID, low bits
    function automatic int bkt(input logic [47:0] mac, input logic [11:0] vid);
        logic [11:0] f = vid;
        for (int i = 0; i < 4; i++) f = f ^ mac[i*12 +: 12];
        return int'(f) % 16;
    endfunction

    // reference walk over the bench's own copy of both memories
    function automatic bit lookup(input logic [47:0] mac, input logic [11:0] vid,
                                  output logic [81:0] e);
        int hops = 0;
        e = head_m[bkt(mac, vid)];
        forever begin
            if (e[81] && e[80:33] == mac && e[32:21] == vid) return 1'b1;
            if (e[11:0] == 12'hFFF || hops == MAX_HOPS) return 1'b0;
            e = chain_m[e[3:0]];
            hops++;
        end
    endfunction

    task automatic wr_chain(input int idx, input logic [81:0] e);
        chain_m[idx] = e;
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = IDX_W'(idx); tbl_wr_data = e;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // put a key at a given depth: 0 = chain head, n = n-th internal entry
    task automatic place(input logic [47:0] mac, input logic [11:0] vid, input bit tr,
                         input logic [7:0] fwd, input int depth);
        int b = bkt(mac, vid);
        if (depth == 0) begin
            head_m[b] = mk(1, mac, vid, tr, fwd, 12'hFFF);
        end else begin
            head_m[b] = mk(1, 48'h0000_00AB_0000 + 48'(alloc + 100), vid, 0, 8'h00, 12'(alloc));
            for (int i = 1; i <= depth; i++) begin
                int idx = alloc;
                alloc++;
                if (i == depth) wr_chain(idx, mk(1, mac, vid, tr, fwd, 12'hFFF));
                else wr_chain(idx, mk(1, 48'h0000_00AB_0000 + 48'(idx), vid, 0, 8'h00, 12'(alloc)));
            end
        end
    endtask

    // external memory: rotating latency of 1..4 cycles, address checked (R2, R4)
    initial begin : ext_model
        logic [BKT_W-1:0] a;
        logic [BKT_W-1:0] e;
        int lat;
        forever begin
            @(negedge clk);
            if (rst_n && ext_rd_req) begin
                a = ext_rd_addr;
                lat = 1 + (n_ext % 4);
                n_ext++;
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R8", "unexpected head read", 64'(a), 64'hFFFF);
                end else begin
                    e = exp_addr.pop_front();
                    chk(a == e, "R2", "bucket address", 64'(a), 64'(e));
                end
                repeat (lat) @(negedge clk);
                ext_rd_valid = 1'b1;
                ext_rd_data  = head_m[a];
                @(negedge clk);
                ext_rd_valid = 1'b0;
            end
        end
    end

    // R12: no response strobe outside a request
    initial begin : stray_done
        forever begin
            @(negedge clk);
            if (rst_n && resp_done && !in_req)
                chk(1'b0, "R12", "stray resp_done", 64'd1, 64'd0);
        end
    end

    task automatic run_req(input logic [47:0] s, input logic [47:0] d, input logic [11:0] v,
                           input bit hold, input string tag);
        logic [81:0] es, ed;
        bit hs, hd;
        logic [1:0] k;
        bit x_learn, x_flood, x_trunk;
        logic [7:0] x_fwd;
        logic [2:0] x_mem;
        logic [3:0] cnt;
        int n;
        bit busy_bad;
        k = (d == BCAST) ? 2'd2 : (d[40] ? 2'd1 : 2'd0);
        hs = lookup(s, v, es);
        x_learn = !hs;
        x_flood = 1; x_trunk = 0; x_fwd = 0; x_mem = 0;
        exp_addr.push_back(BKT_W'(bkt(s, v)));
        if (k != 2'd2) begin
            exp_addr.push_back(BKT_W'(bkt(d, v)));
            hd = lookup(d, v, ed);
            if (hd) begin
                x_flood = 0;
                if (k == 2'd0 && ed[20]) begin
                    x_trunk = 1;
                    x_fwd = {5'd0, ed[14:12]};
                    cnt = trunk_cnt[ed[14:12]*4 +: 4];
                    x_mem = (cnt == 0) ? 3'd0 : 3'((int'(s[2:0] ^ d[2:0])) % int'(cnt));
                end else begin
                    x_fwd = ed[19:12];
                end
            end
        end
        in_req = 1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R3", {tag, " ready before request"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_src_mac = s; req_dst_mac = d; req_vid = v;
        @(negedge clk);
        if (hold) begin
            req_src_mac = ~s; req_dst_mac = ~d; req_vid = ~v;
        end else begin
            req_valid = 1'b0;
        end
        n = 0; busy_bad = 0;
        while (!resp_done && n < 300) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(!busy_bad, "R3", {tag, " ready low while busy"}, 64'(busy_bad), 64'd0);
        chk(resp_done == 1'b1, "R4", {tag, " response arrived"}, 64'(resp_done), 64'd1);
        chk(resp_kind == k, "R9", {tag, " kind"}, 64'(resp_kind), 64'(k));
        chk(resp_learn == x_learn, "R7", {tag, " learn"}, 64'(resp_learn), 64'(x_learn));
        chk(resp_flood == x_flood, (k == 2'd2) ? "R8" : "R10", {tag, " flood"},
            64'(resp_flood), 64'(x_flood));
        chk(resp_trunk == x_trunk, "R11", {tag, " trunk"}, 64'(resp_trunk), 64'(x_trunk));
        chk(resp_fwd == x_fwd, "R11", {tag, " fwd"}, 64'(resp_fwd), 64'(x_fwd));
        chk(resp_member == x_mem, "R11", {tag, " member"}, 64'(resp_member), 64'(x_mem));
        chk(exp_addr.size() == 0, "R8", {tag, " head reads consumed"},
            64'(exp_addr.size()), 64'd0);
        @(negedge clk);
        chk(resp_done == 1'b0, "R12", {tag, " strobe one cycle"}, 64'(resp_done), 64'd0);
        in_req = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12", "watchdog expired", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [47:0] ma, mb, ms7;
        int ext_before;
        for (int i = 0; i < 16; i++) begin
            head_m[i]  = mk(0, 48'h0, 12'h0, 0, 8'h0, 12'hFFF);
            chain_m[i] = mk(0, 48'h0, 12'h0, 0, 8'h0, 12'hFFF);
        end
        trunk_cnt[3*4 +: 4] = 4'd3;
        trunk_cnt[6*4 +: 4] = 4'd5;
        trunk_cnt[2*4 +: 4] = 4'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(resp_done == 1'b0, "R1", "done after reset", 64'(resp_done), 64'd0);
        chk(ext_rd_req == 1'b0, "R1", "ext read after reset", 64'(ext_rd_req), 64'd0);

        ma  = 48'h0011_2233_4455;
        mb  = 48'h00AA_BBCC_DD06;
        ms7 = 48'h0044_0000_0007;
        place(ma, 12'h010, 0, 8'h01, 0);
        place(mb, 12'h010, 0, 8'h05, 0);
        run_req(ma, mb, 12'h010, 0, "R7 R11 both heads hit");

        // R5 chained destination, R7 unknown source
        place(48'h00DD_0000_0102, 12'h010, 0, 8'h07, 2);
        run_req(48'h0012_3456_789A, 48'h00DD_0000_0102, 12'h010, 0, "R5 chain depth 2");

        // R10 unknown destination
        run_req(ma, 48'h00EE_1234_0000, 12'h010, 0, "R10 unicast miss");

        // R6 key exactly at the hop cap, then one past it
        place(48'h00C0_0000_0203, 12'h010, 0, 8'h09, 3);
        run_req(ma, 48'h00C0_0000_0203, 12'h010, 0, "R6 at cap");
        place(48'h00C1_0000_0304, 12'h010, 0, 8'h0B, 4);
        run_req(ma, 48'h00C1_0000_0304, 12'h010, 0, "R6 past cap");

        // R8 broadcast
        run_req(ma, BCAST, 12'h010, 0, "R8 broadcast");

        // R9 multicast hit on an entry with the trunk flag set, and a miss
        place(48'h0100_5E00_0021, 12'h010, 1, 8'hA5, 0);
        run_req(ma, 48'h0100_5E00_0021, 12'h010, 0, "R9 multicast hit");
        run_req(ma, 48'h0100_5E00_0099, 12'h010, 0, "R9 multicast miss");

        // R11 trunk members
        place(48'h0033_0000_0008, 12'h010, 1, 8'h03, 0);
        run_req(ma, 48'h0033_0000_0008, 12'h010, 0, "R11 trunk cnt 3");
        place(ms7, 12'h010, 0, 8'h02, 0);
        place(48'h0033_0000_0011, 12'h010, 1, 8'h06, 0);
        run_req(ms7, 48'h0033_0000_0011, 12'h010, 0, "R11 trunk cnt 5");
        place(48'h0033_0000_0022, 12'h010, 1, 8'h02, 0);
        run_req(ma, 48'h0033_0000_0022, 12'h010, 0, "R11 trunk cnt 0");

        // R5 same MACs on another VLAN miss
        run_req(ma, mb, 12'h020, 0, "R5 vid mismatch");

        // R3 inputs changed while busy have no effect
        place(ma, 12'h010, 0, 8'h01, 0);
        place(mb, 12'h010, 0, 8'h05, 0);
        run_req(ma, mb, 12'h010, 1, "R3 busy inputs ignored");
        ext_before = n_ext;
        repeat (8) @(negedge clk);
        chk(n_ext == ext_before, "R3", "no read after busy inputs", 64'(n_ext), 64'(ext_before));
        chk(req_ready == 1'b1, "R3", "idle after busy test", 64'(req_ready), 64'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule